// File: doc/BRIEF.md
# Console I/O Register Bank

This block sits on a 16-bit processor memory bus and answers ordinary load and store cycles whose address falls in the top window of the address space, from `0xFE00` to `0xFFFF`. Inside that window it holds five registers: a status and a data register for a keyboard, a status and a data register for a display, and a machine control word. Software moves characters with normal loads and stores. It can poll the status flags or enable a per-device interrupt request.

On the device side, a keyboard delivers one byte with a single-cycle strobe. The display side presents a pending byte together with a valid flag and takes it when the device acknowledges. The block has two access side effects. Reading the keyboard data register clears the keyboard ready flag. Writing the display data register clears the display done flag. The run latch in the control word drives an output that halts the processor when it is cleared.

Read data is combinational from the address and the read strobe. Every state change, including the side effects of an access, takes place on the rising clock edge that ends the access cycle.

Top module: `console_io_regs`

## Requirements
- R1: `io_sel_o` is 1 exactly when `rd_i` or `wr_i` is 1 and `addr_i >= 0xFE00`. `rdata_o` is 0 for addresses outside the window, for window addresses that hold no register, and whenever `rd_i` is 0.
- R2: After reset, the keyboard status at `0xFE00` reads 0, the display status at `0xFE04` reads `0x8000`, the control word at `0xFFFE` reads `0x8000`, `run_o` is 1, and `dsp_valid_o`, `kbd_irq_o` and `dsp_irq_o` are 0.
- R3: A cycle with `kbd_strobe_i` = 1 loads `kbd_data_i` into the keyboard data register at `0xFE02` (bits 7:0, upper bits read 0) and sets the ready flag (bit 15 of `0xFE00`).
- R4: A read of `0xFE02` returns the held byte and clears the ready flag at the end of that cycle. If a strobe arrives in the same cycle, the new byte is loaded and ready stays 1.
- R5: A strobe while ready is already 1 overwrites the held byte, and ready stays 1.
- R6: Bit 14 of each status register is a read/write interrupt enable. Writes to bit 15 of either status register are ignored, and all other status bits read 0.
- R7: A write to `0xFE06` places `wdata_i[7:0]` on `dsp_data_o`, clears the done flag (bit 15 of `0xFE04`) and raises `dsp_valid_o`. A read of `0xFE06` returns the byte with the upper bits 0.
- R8: `dsp_ack_i` while the done flag is 0 sets done and drops `dsp_valid_o`. An ack while done is already 1 has no effect. A data write in the same cycle as an ack wins.
- R9: `kbd_irq_o` is 1 exactly when keyboard ready and its enable are both 1, and `dsp_irq_o` is 1 exactly when display done and its enable are both 1.
- R10: Bit 15 of the control word at `0xFFFE` is a read/write run latch that drives `run_o`. Writing 0 to it drives `run_o` low. Other bits read 0.
- R11: The keyboard data register is read only. A write to `0xFE02` changes neither the held byte nor the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| rd_i | input | 1 | Read cycle |
| wr_i | input | 1 | Write cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| io_sel_o | output | 1 | Access hits the I/O window |
| kbd_data_i | input | 8 | Incoming keyboard byte |
| kbd_strobe_i | input | 1 | Keyboard byte valid, one cycle |
| dsp_data_o | output | 8 | Outgoing display byte |
| dsp_valid_o | output | 1 | Display byte pending |
| dsp_ack_i | input | 1 | Display took the byte |
| kbd_irq_o | output | 1 | Keyboard interrupt request |
| dsp_irq_o | output | 1 | Display interrupt request |
| run_o | output | 1 | Run latch, 0 halts the machine |

## Verification
The keyboard path is exercised with a single byte, with two bytes back to back without a read in between, and with a read that coincides with a strobe. These three patterns separate a plain set and clear of the ready flag from overwrite handling and from the priority between the two side effects. The display path runs a write followed by one ack and then a second, redundant ack, which shows whether done is set only by a pending byte. Writes of all ones and all zeros to the status and control words, together with accesses to unused and out-of-window addresses, show whether each bit is writable, ignored or always 0.

// File: rtl/console_io_pkg.sv
package console_io_pkg;
  // register offsets from the window base
  localparam int unsigned KSTAT_OFS = 'h000;
  localparam int unsigned KDATA_OFS = 'h002;
  localparam int unsigned DSTAT_OFS = 'h004;
  localparam int unsigned DDATA_OFS = 'h006;
  localparam int unsigned MCTL_OFS  = 'h1FE;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA,
    SEL_MCTL
  } reg_sel_e;
endpackage

// File: rtl/cio_decode.sv
module cio_decode
  import console_io_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFE00
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              io_sel_o,
  output logic              in_win_o,
  output reg_sel_e          sel_o
);
  logic [ADDR_W-1:0] ofs;

  assign in_win_o = (addr_i >= WIN_BASE);
  assign io_sel_o = in_win_o && (rd_i || wr_i);
  assign ofs      = addr_i - WIN_BASE;

  always_comb begin
    sel_o = SEL_NONE;
    if (in_win_o) begin
      if      (ofs == ADDR_W'(KSTAT_OFS)) sel_o = SEL_KSTAT;
      else if (ofs == ADDR_W'(KDATA_OFS)) sel_o = SEL_KDATA;
      else if (ofs == ADDR_W'(DSTAT_OFS)) sel_o = SEL_DSTAT;
      else if (ofs == ADDR_W'(DDATA_OFS)) sel_o = SEL_DDATA;
      else if (ofs == ADDR_W'(MCTL_OFS))  sel_o = SEL_MCTL;
    end
  end
endmodule

// File: rtl/cio_kbd.sv
module cio_kbd #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              data_rd_i,
  input  logic              stat_wr_i,
  input  logic              ie_wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              ie_o,
  output logic              irq_o
);
  localparam int unsigned FLAG_B = DATA_W - 1;
  localparam int unsigned IE_B   = DATA_W - 2;

  logic [CHAR_W-1:0] char_q;
  logic              ready_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q  <= '0;
      ready_q <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      // arrival outranks the clearing read
      if (strobe_i) begin
        char_q  <= char_i;
        ready_q <= 1'b1;
      end else if (data_rd_i) begin
        ready_q <= 1'b0;
      end
      if (stat_wr_i) ie_q <= ie_wdata_i;
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[FLAG_B] = ready_q;
    stat_o[IE_B]   = ie_q;
    data_o         = '0;
    data_o[CHAR_W-1:0] = char_q;
  end

  assign ready_o = ready_q;
  assign ie_o    = ie_q;
  assign irq_o   = ready_q & ie_q;
endmodule

// File: rtl/cio_dsp.sv
module cio_dsp #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [CHAR_W-1:0] char_wdata_i,
  input  logic              stat_wr_i,
  input  logic              ie_wdata_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int unsigned FLAG_B = DATA_W - 1;
  localparam int unsigned IE_B   = DATA_W - 2;

  logic [CHAR_W-1:0] char_q;
  logic              done_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q <= '0;
      done_q <= 1'b1;
      ie_q   <= 1'b0;
    end else begin
      // a fresh byte outranks the device ack
      if (data_wr_i) begin
        char_q <= char_wdata_i;
        done_q <= 1'b0;
      end else if (ack_i && !done_q) begin
        done_q <= 1'b1;
      end
      if (stat_wr_i) ie_q <= ie_wdata_i;
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[FLAG_B] = done_q;
    stat_o[IE_B]   = ie_q;
    data_o         = '0;
    data_o[CHAR_W-1:0] = char_q;
  end

  assign char_o  = char_q;
  assign valid_o = ~done_q;
  assign done_o  = done_q;
  assign irq_o   = done_q & ie_q;
endmodule

// File: rtl/cio_mctl.sv
module cio_mctl #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              run_wdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic              run_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= 1'b1;
    else if (wr_i) run_q <= run_wdata_i;
  end

  always_comb begin
    word_o           = '0;
    word_o[DATA_W-1] = run_q;
  end

  assign run_o = run_q;
endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
  import console_io_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 16,
  parameter int unsigned       CHAR_W   = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFE00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              io_sel_o,
  input  logic [CHAR_W-1:0] kbd_data_i,
  input  logic              kbd_strobe_i,
  output logic [CHAR_W-1:0] dsp_data_o,
  output logic              dsp_valid_o,
  input  logic              dsp_ack_i,
  output logic              kbd_irq_o,
  output logic              dsp_irq_o,
  output logic              run_o
);
  localparam int unsigned IE_B = DATA_W - 2;

  reg_sel_e          sel;
  logic              in_win;
  logic              kdata_rd, kstat_wr, dstat_wr, ddata_wr, mctl_wr;
  logic              kbd_ready, kbd_ie, dsp_done;
  logic [DATA_W-1:0] kstat_w, kdata_w, dstat_w, ddata_w, mctl_w;

  cio_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .io_sel_o(io_sel_o),
    .in_win_o(in_win),
    .sel_o   (sel)
  );

  assign kdata_rd = rd_i && (sel == SEL_KDATA);
  assign kstat_wr = wr_i && (sel == SEL_KSTAT);
  assign dstat_wr = wr_i && (sel == SEL_DSTAT);
  assign ddata_wr = wr_i && (sel == SEL_DDATA);
  assign mctl_wr  = wr_i && (sel == SEL_MCTL);

  cio_kbd #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_kbd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (kbd_strobe_i),
    .char_i    (kbd_data_i),
    .data_rd_i (kdata_rd),
    .stat_wr_i (kstat_wr),
    .ie_wdata_i(wdata_i[IE_B]),
    .stat_o    (kstat_w),
    .data_o    (kdata_w),
    .ready_o   (kbd_ready),
    .ie_o      (kbd_ie),
    .irq_o     (kbd_irq_o)
  );

  cio_dsp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_wr_i   (ddata_wr),
    .char_wdata_i(wdata_i[CHAR_W-1:0]),
    .stat_wr_i   (dstat_wr),
    .ie_wdata_i  (wdata_i[IE_B]),
    .ack_i       (dsp_ack_i),
    .stat_o      (dstat_w),
    .data_o      (ddata_w),
    .char_o      (dsp_data_o),
    .valid_o     (dsp_valid_o),
    .done_o      (dsp_done),
    .irq_o       (dsp_irq_o)
  );

  cio_mctl #(.DATA_W(DATA_W)) u_mctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mctl_wr),
    .run_wdata_i(wdata_i[DATA_W-1]),
    .word_o     (mctl_w),
    .run_o      (run_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && in_win) begin
      unique case (sel)
        SEL_KSTAT: rdata_o = kstat_w;
        SEL_KDATA: rdata_o = kdata_w;
        SEL_DSTAT: rdata_o = dstat_w;
        SEL_DDATA: rdata_o = ddata_w;
        SEL_MCTL:  rdata_o = mctl_w;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/console_io_regs_chk.sv
module console_io_regs_chk #(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 16,
  parameter int unsigned       CHAR_W   = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFE00
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              io_sel_o,
  input logic              kbd_strobe_i,
  input logic              dsp_ack_i,
  input logic [CHAR_W-1:0] dsp_data_o,
  input logic              kbd_irq_o,
  input logic              run_o,
  input logic              kbd_ready,
  input logic              dsp_done,
  input logic              kdata_rd,
  input logic              kstat_wr,
  input logic              ddata_wr,
  input logic              mctl_wr
);
  a_r1_outside_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < WIN_BASE) |-> (!io_sel_o && rdata_o == '0));

  a_r3_strobe_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_strobe_i |=> kbd_ready);

  a_r4_read_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kdata_rd && !kbd_strobe_i) |=> !kbd_ready);

  a_r6_ready_ignores_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kstat_wr && !kbd_strobe_i && !kdata_rd) |=> (kbd_ready == $past(kbd_ready)));

  a_r7_write_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddata_wr |=> (!dsp_done && dsp_data_o == $past(wdata_i[CHAR_W-1:0])));

  a_r8_ack_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_ack_i && !dsp_done && !ddata_wr) |=> dsp_done);

  a_r9_kbd_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kbd_irq_o) |-> ($past(kbd_strobe_i) || $past(kstat_wr)));

  a_r10_run_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mctl_wr |=> (run_o == $past(wdata_i[DATA_W-1])));

  a_r10_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mctl_wr || !wr_i) |=> $stable(run_o));
endmodule

bind console_io_regs console_io_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .io_sel_o    (io_sel_o),
  .kbd_strobe_i(kbd_strobe_i),
  .dsp_ack_i   (dsp_ack_i),
  .dsp_data_o  (dsp_data_o),
  .kbd_irq_o   (kbd_irq_o),
  .run_o       (run_o),
  .kbd_ready   (kbd_ready),
  .dsp_done    (dsp_done),
  .kdata_rd    (kdata_rd),
  .kstat_wr    (kstat_wr),
  .ddata_wr    (ddata_wr),
  .mctl_wr     (mctl_wr)
);

// File: tb/console_io_regs_tb_top.sv
`timescale 1ns/1ps
module console_io_regs_tb_top;
  localparam logic [15:0] A_KS = 16'hFE00, A_KD = 16'hFE02, A_DS = 16'hFE04,
                          A_DD = 16'hFE06, A_MC = 16'hFFFE;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] rdata;
  logic        io_sel;
  logic [7:0]  kbd_data = '0;
  logic        kbd_strobe = 1'b0;
  logic [7:0]  dsp_data;
  logic        dsp_valid;
  logic        dsp_ack = 1'b0;
  logic        kbd_irq, dsp_irq, run;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  console_io_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .io_sel_o(io_sel),
    .kbd_data_i(kbd_data), .kbd_strobe_i(kbd_strobe),
    .dsp_data_o(dsp_data), .dsp_valid_o(dsp_valid), .dsp_ack_i(dsp_ack),
    .kbd_irq_o(kbd_irq), .dsp_irq_o(dsp_irq), .run_o(run)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic kbd_send(input logic [7:0] c);
    @(negedge clk); kbd_data = c; kbd_strobe = 1'b1;
    @(negedge clk); kbd_strobe = 1'b0;
  endtask

  task automatic dsp_take();
    @(negedge clk); dsp_ack = 1'b1;
    @(negedge clk); dsp_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bus_rd(A_KS, v); check(v == 16'h0000, "R2 kbd status", v, 16'h0000);
    bus_rd(A_DS, v); check(v == 16'h8000, "R2 dsp status", v, 16'h8000);
    bus_rd(A_MC, v); check(v == 16'h8000, "R2 control", v, 16'h8000);
    check(run && !dsp_valid && !kbd_irq && !dsp_irq, "R2 outputs",
          {12'h0, run, dsp_valid, kbd_irq, dsp_irq}, 16'h0008);
  endtask

  task automatic t_window();
    logic [15:0] v;
    @(negedge clk); addr = 16'h3000; rd = 1'b1;
    #1 check(!io_sel && rdata == 0, "R1 low address", {io_sel, rdata[14:0]}, 16'h0);
    addr = 16'hFDFF;
    #1 check(!io_sel && rdata == 0, "R1 below window", {io_sel, rdata[14:0]}, 16'h0);
    addr = 16'hFE08;
    #1 check(io_sel && rdata == 0, "R1 unused slot", {io_sel, rdata[14:0]}, 16'h8000);
    @(negedge clk); rd = 1'b0; addr = A_MC;
    #1 check(!io_sel && rdata == 0, "R1 idle bus", {io_sel, rdata[14:0]}, 16'h0);
    bus_rd(16'hFE01, v); check(v == 0, "R1 odd slot", v, 16'h0);
  endtask

  task automatic t_kbd_basic();
    logic [15:0] v;
    kbd_send(8'h41);
    bus_rd(A_KS, v); check(v == 16'h8000, "R3 ready set", v, 16'h8000);
    bus_rd(A_KD, v); check(v == 16'h0041, "R3 char", v, 16'h0041);
    bus_rd(A_KS, v); check(v == 16'h0000, "R4 read clears", v, 16'h0000);
  endtask

  task automatic t_kbd_overwrite();
    logic [15:0] v;
    kbd_send(8'h42);
    kbd_send(8'h43);
    bus_rd(A_KS, v); check(v == 16'h8000, "R5 ready kept", v, 16'h8000);
    bus_rd(A_KD, v); check(v == 16'h0043, "R5 newest char", v, 16'h0043);
  endtask

  task automatic t_kbd_race();
    logic [15:0] v;
    kbd_send(8'h44);
    @(negedge clk); addr = A_KD; rd = 1'b1; kbd_data = 8'h45; kbd_strobe = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0; kbd_strobe = 1'b0;
    check(v == 16'h0044, "R4 race old char", v, 16'h0044);
    bus_rd(A_KS, v); check(v == 16'h8000, "R4 race ready", v, 16'h8000);
    bus_rd(A_KD, v); check(v == 16'h0045, "R4 race new char", v, 16'h0045);
  endtask

  task automatic t_kbd_readonly();
    logic [15:0] v;
    bus_wr(A_KD, 16'hFFFF);
    bus_rd(A_KS, v); check(v == 16'h0000, "R11 ready untouched", v, 16'h0000);
    bus_rd(A_KD, v); check(v == 16'h0045, "R11 char untouched", v, 16'h0045);
  endtask

  task automatic t_kbd_irq();
    logic [15:0] v;
    bus_wr(A_KS, 16'hFFFF);
    bus_rd(A_KS, v); check(v == 16'h4000, "R6 kbd status bits", v, 16'h4000);
    check(!kbd_irq, "R9 kbd irq idle", {15'h0, kbd_irq}, 16'h0);
    kbd_send(8'h0A);
    #1 check(kbd_irq, "R9 kbd irq up", {15'h0, kbd_irq}, 16'h1);
    bus_rd(A_KD, v);
    #1 check(!kbd_irq, "R9 kbd irq down", {15'h0, kbd_irq}, 16'h0);
    bus_wr(A_KS, 16'h0000);
    bus_rd(A_KS, v); check(v == 16'h0000, "R6 kbd ie off", v, 16'h0000);
  endtask

  task automatic t_display();
    logic [15:0] v;
    bus_wr(A_DD, 16'h1234);
    #1 check(dsp_data == 8'h34 && dsp_valid, "R7 outputs",
             {7'h0, dsp_valid, dsp_data}, 16'h0134);
    bus_rd(A_DS, v); check(v == 16'h0000, "R7 done cleared", v, 16'h0000);
    bus_rd(A_DD, v); check(v == 16'h0034, "R7 readback", v, 16'h0034);
    dsp_take();
    #1 check(!dsp_valid, "R8 valid drops", {15'h0, dsp_valid}, 16'h0);
    bus_rd(A_DS, v); check(v == 16'h8000, "R8 done set", v, 16'h8000);
    dsp_take();
    bus_rd(A_DS, v); check(v == 16'h8000, "R8 extra ack", v, 16'h8000);
    bus_wr(A_DS, 16'h0000);
    bus_rd(A_DS, v); check(v == 16'h8000, "R6 done ignores write", v, 16'h8000);
    bus_wr(A_DS, 16'h4000);
    #1 check(dsp_irq, "R9 dsp irq up", {15'h0, dsp_irq}, 16'h1);
    @(negedge clk); addr = A_DD; wdata = 16'h0055; wr = 1'b1; dsp_ack = 1'b1;
    @(negedge clk); wr = 1'b0; dsp_ack = 1'b0;
    #1 check(!dsp_irq && dsp_valid && dsp_data == 8'h55, "R8 write beats ack",
             {6'h0, dsp_irq, dsp_valid, dsp_data}, 16'h0155);
    dsp_take();
    bus_rd(A_DS, v); check(v == 16'hC000, "R9 dsp status", v, 16'hC000);
    bus_wr(A_DS, 16'h0000);
    #1 check(!dsp_irq, "R9 dsp irq off", {15'h0, dsp_irq}, 16'h0);
  endtask

  task automatic t_control();
    logic [15:0] v;
    bus_wr(A_MC, 16'h7FFF);
    #1 check(!run, "R10 halt", {15'h0, run}, 16'h0);
    bus_rd(A_MC, v); check(v == 16'h0000, "R10 readback low", v, 16'h0000);
    bus_wr(A_MC, 16'h8000);
    #1 check(run, "R10 resume", {15'h0, run}, 16'h1);
    bus_wr(A_MC, 16'hFFFF);
    bus_rd(A_MC, v); check(v == 16'h8000, "R10 other bits", v, 16'h8000);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_kbd_basic();
    t_kbd_overwrite();
    t_kbd_race();
    t_kbd_readonly();
    t_kbd_irq();
    t_display();
    t_control();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule